// File: doc/BRIEF.md
# Key Store Command Gatekeeper

This block sits between a command decoder and the resources of a small secure key store. It judges each decoded command against three things: a key-valid flag, a personalization marker, and an external watchdog count. It answers every command it takes with a one-cycle accept strobe or a one-cycle error strobe. It also drives the side effects a command is allowed to have: a one-cycle start request to an external hash engine, a fuse-burn request, and a one-cycle write enable for the 256-bit key memory. The block itself keeps 88 one-time fuse bits and a read path for status words.

The key memory can be written once. A write is granted only while the key-valid flag is clear, and only when a seed command finished as the very command before it. Once the write succeeds, the flag stays set until power-on reset. The hash engine sits outside the block and talks to it only through `hash_start`/`hash_done`. When the watchdog count reaches zero, the block drops its current activity and enters sleep. A wake pulse brings it back to idle.

Top module: `keystore_cmd_policy`

## Requirements
- R1: After power-on reset the key-valid flag is 0, all fuse bits are 0, no strobe is active, and `busy` and `asleep` are both 0.
- R2: Every command taken in idle produces, in the next cycle, exactly one of `accept` or `error`, or a `hash_start`. Any opcode other than 0x02 (read), 0x17 (burn), 0x08 (digest), 0x20 (seed), 0x10 (key load) and 0x01 (pause) produces `error`.
- R3: A read selects its source with `cmd_p1`: 0 is fuses, 1 is the identifier word, 2 is the key-valid flag in bit 0. It selects the word with `cmd_p2[1:0]`, and `cmd_p2[15:2]` has no effect. Fuse word n holds fuse bits 32n to 32n+31, and bits above 87 read as 0. The identifier word is ROM_ID XOR the address. A fuse word address of 3, or a source above 2, gives `error`.
- R4: A burn of index `cmd_p1` below 88 pulses `fuse_burn_req` with `fuse_burn_idx` equal to that index, accepts, and sets that fuse bit. An index of 88 or above gives `error`. Fuse bits never return from 1 to 0.
- R5: A burn is refused with `error`, with no request and no fuse change, when `supply_ok` is 0 or when `wdog_cnt` is below FUSE_T.
- R6: A digest with the key-valid flag clear gives `error` and no `hash_start`. With the flag set, it pulses `hash_start`, then accepts in the cycle after `hash_done` is sampled.
- R7: A seed pulses `hash_start` and accepts in the cycle after `hash_done` is sampled. This sets the seed marker.
- R8: A key load without the seed marker set gives `error` and no `key_wr_en`.
- R9: A key load with the marker set and the key-valid flag clear pulses `key_wr_en`, accepts, and sets the key-valid flag. A key load while the flag is set gives `error`. The flag stays set until reset.
- R10: Every command taken, and every watchdog expiry, clears the seed marker. Only the completion of a seed sets it.
- R11: A pause accepts and raises `busy`. While paused, commands produce no strobe. A zero watchdog count then moves the block to sleep.
- R12: When `wdog_cnt` is 0 in any state other than sleep, the block enters sleep on that edge with no strobe, and any command in that cycle is discarded.
- R13: In sleep, commands produce no strobe. A `wake` pulse returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 8 | Opcode |
| cmd_p1 | input | 8 | First parameter (read source or fuse index) |
| cmd_p2 | input | 16 | Second parameter (read word address) |
| supply_ok | input | 1 | Supply high enough to burn fuses |
| wdog_cnt | input | WD_W | Cycles left before watchdog expiry; 0 means expired |
| wake | input | 1 | Wake pulse out of sleep |
| hash_done | input | 1 | Hash engine finished |
| accept | output | 1 | Command completed successfully (one cycle) |
| error | output | 1 | Command refused (one cycle) |
| rd_data | output | 32 | Read result, valid with `accept` of a read |
| hash_start | output | 1 | Start request to the hash engine |
| fuse_burn_req | output | 1 | Burn request for one fuse (one cycle) |
| fuse_burn_idx | output | FI_W | Index of the fuse to burn |
| key_wr_en | output | 1 | Key memory write enable (one cycle) |
| key_valid | output | 1 | Key memory holds a loaded key |
| busy | output | 1 | Waiting for the hash engine or paused |
| asleep | output | 1 | Sleep state |

## Verification
Watchdog expiry and an incoming command can fall in the same cycle. To provoke this, the bench presents a read at the same edge where it drives `wdog_cnt` to zero. The pass condition is that no strobe appears and `asleep` rises. A second case lets the count expire during the single cycle between a completed seed and the next key load. The following key load must then be refused, which shows that expiry also cleared the personalization marker.

// File: rtl/keystore_cmd_policy.sv
module keystore_cmd_policy #(
  parameter int          NFUSE  = 88,
  parameter int          WD_W   = 16,
  parameter int          FUSE_T = 16,
  parameter logic [31:0] ROM_ID = 32'h5EC0_0C00,
  localparam int         FI_W   = $clog2(NFUSE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_op,
  input  logic [7:0]      cmd_p1,
  input  logic [15:0]     cmd_p2,
  input  logic            supply_ok,
  input  logic [WD_W-1:0] wdog_cnt,
  input  logic            wake,
  input  logic            hash_done,
  output logic            accept,
  output logic            error,
  output logic [31:0]     rd_data,
  output logic            hash_start,
  output logic            fuse_burn_req,
  output logic [FI_W-1:0] fuse_burn_idx,
  output logic            key_wr_en,
  output logic            key_valid,
  output logic            busy,
  output logic            asleep
);
  localparam int          NWORD = (NFUSE + 31) / 32;
  localparam logic [7:0]  NF8   = 8'(NFUSE);
  localparam logic [WD_W-1:0] FT = WD_W'(FUSE_T);

  localparam logic [7:0] OP_PAUSE = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h02;
  localparam logic [7:0] OP_MAC   = 8'h08;
  localparam logic [7:0] OP_KEY   = 8'h10;
  localparam logic [7:0] OP_BURN  = 8'h17;
  localparam logic [7:0] OP_SEED  = 8'h20;

  typedef enum logic [1:0] {S_IDLE, S_HASH, S_PAUSE, S_SLEEP} state_t;

  state_t            state;
  logic [NFUSE-1:0]  fuse_q;
  logic              seed_mark, seed_pend;
  logic [NWORD*32-1:0] fpad;
  logic [31:0]       fword, rd_word;
  logic              rd_ok, burn_ok, expired;
  logic [1:0]        addr;
  logic              unused_bits;

  assign addr        = cmd_p2[1:0];
  assign unused_bits = ^cmd_p2[15:2];
  assign expired     = (wdog_cnt == '0);
  assign busy        = (state == S_HASH) || (state == S_PAUSE);
  assign asleep      = (state == S_SLEEP);
  assign burn_ok     = supply_ok && (cmd_p1 < NF8) && (wdog_cnt >= FT);

  always_comb begin
    fpad = '0;
    fpad[NFUSE-1:0] = fuse_q;
    fword = '0;
    for (int w = 0; w < NWORD; w++)
      if (32'(addr) == w) fword = fpad[w*32 +: 32];
  end

  always_comb begin
    rd_ok   = 1'b1;
    rd_word = '0;
    case (cmd_p1)
      8'd0: begin rd_ok = (32'(addr) < NWORD); rd_word = fword; end
      8'd1: rd_word = ROM_ID ^ {30'd0, addr};
      8'd2: rd_word = {31'd0, key_valid};
      default: rd_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      fuse_q        <= '0;
      seed_mark     <= 1'b0;
      seed_pend     <= 1'b0;
      key_valid     <= 1'b0;
      accept        <= 1'b0;
      error         <= 1'b0;
      rd_data       <= '0;
      hash_start    <= 1'b0;
      fuse_burn_req <= 1'b0;
      fuse_burn_idx <= '0;
      key_wr_en     <= 1'b0;
    end else begin
      accept        <= 1'b0;
      error         <= 1'b0;
      hash_start    <= 1'b0;
      fuse_burn_req <= 1'b0;
      key_wr_en     <= 1'b0;
      if (state != S_SLEEP && expired) begin
        state     <= S_SLEEP;
        seed_mark <= 1'b0;
      end else begin
        case (state)
          S_IDLE: if (cmd_valid) begin
            seed_mark <= 1'b0;
            case (cmd_op)
              OP_READ: if (rd_ok) begin
                accept  <= 1'b1;
                rd_data <= rd_word;
              end else error <= 1'b1;
              OP_BURN: if (burn_ok) begin
                accept        <= 1'b1;
                fuse_burn_req <= 1'b1;
                fuse_burn_idx <= cmd_p1[FI_W-1:0];
                fuse_q[cmd_p1[FI_W-1:0]] <= 1'b1;
              end else error <= 1'b1;
              OP_MAC: if (key_valid) begin
                hash_start <= 1'b1;
                seed_pend  <= 1'b0;
                state      <= S_HASH;
              end else error <= 1'b1;
              OP_SEED: begin
                hash_start <= 1'b1;
                seed_pend  <= 1'b1;
                state      <= S_HASH;
              end
              OP_KEY: if (!key_valid && seed_mark) begin
                key_wr_en <= 1'b1;
                key_valid <= 1'b1;
                accept    <= 1'b1;
              end else error <= 1'b1;
              OP_PAUSE: begin
                accept <= 1'b1;
                state  <= S_PAUSE;
              end
              default: error <= 1'b1;
            endcase
          end
          S_HASH: if (hash_done) begin
            accept    <= 1'b1;
            seed_mark <= seed_pend;
            state     <= S_IDLE;
          end
          S_PAUSE: ;
          S_SLEEP: if (wake) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/keystore_cmd_policy_chk.sv
module keystore_cmd_policy_chk #(
  parameter int NFUSE = 88,
  parameter int WD_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             error,
  input logic             key_wr_en,
  input logic             key_valid,
  input logic             fuse_burn_req,
  input logic             supply_ok,
  input logic             asleep,
  input logic [WD_W-1:0]  wdog_cnt,
  input logic [NFUSE-1:0] fuse_q
);
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n) !(accept && error)); // R2
  AST_FUSE_MONO: assert property (@(posedge clk) disable iff (!rst_n) (($past(fuse_q) & ~fuse_q) == '0)); // R4
  AST_BURN_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n) fuse_burn_req |-> $past(supply_ok)); // R5
  AST_KEY_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $past(key_valid) |-> key_valid); // R9
  AST_KEY_WR_ONCE: assert property (@(posedge clk) disable iff (!rst_n) key_wr_en |-> !$past(key_valid)); // R9
  AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rst_n) (wdog_cnt == '0 && !asleep) |=> (asleep && !accept && !error)); // R12
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) asleep |-> (!accept && !error)); // R13
endmodule

bind keystore_cmd_policy keystore_cmd_policy_chk #(.NFUSE(NFUSE), .WD_W(WD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .error(error), .key_wr_en(key_wr_en),
  .key_valid(key_valid), .fuse_burn_req(fuse_burn_req), .supply_ok(supply_ok),
  .asleep(asleep), .wdog_cnt(wdog_cnt), .fuse_q(fuse_q)
);

// File: tb/sim_keystore_cmd_policy.sv
module sim_keystore_cmd_policy;
  localparam int CLK_P = 10;
  localparam logic [31:0] ROM_ID = 32'h5EC0_0C00;
  localparam logic [15:0] WD_OK = 16'd1000;

  logic clk = 0, rst_n = 0, cmd_valid = 0, supply_ok = 1, wake = 0, hash_done = 0;
  logic [7:0] cmd_op = 0, cmd_p1 = 0;
  logic [15:0] cmd_p2 = 0, wdog_cnt = WD_OK;
  logic accept, error, hash_start, fuse_burn_req, key_wr_en, key_valid, busy, asleep;
  logic [31:0] rd_data;
  logic [6:0] fuse_burn_idx;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  keystore_cmd_policy u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_p1(cmd_p1),
    .cmd_p2(cmd_p2), .supply_ok(supply_ok), .wdog_cnt(wdog_cnt), .wake(wake),
    .hash_done(hash_done), .accept(accept), .error(error), .rd_data(rd_data),
    .hash_start(hash_start), .fuse_burn_req(fuse_burn_req), .fuse_burn_idx(fuse_burn_idx),
    .key_wr_en(key_wr_en), .key_valid(key_valid), .busy(busy), .asleep(asleep)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [7:0] op, logic [7:0] p1, logic [15:0] p2);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_p1 = p1; cmd_p2 = p2;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic finish_hash(string req);
    check({req, " hash_start"}, hash_start, 1);
    @(negedge clk); hash_done = 1;
    @(negedge clk); hash_done = 0;
    check({req, " accept after done"}, {accept, error}, 2'b10);
  endtask

  task automatic sleep_and_wake();
    @(negedge clk); wdog_cnt = 0;
    @(negedge clk); wdog_cnt = WD_OK;
    check("R12 asleep after expiry", asleep, 1);
    wake = 1;
    @(negedge clk); wake = 0;
    check("R13 idle after wake", {asleep, busy}, 2'b00);
  endtask

  task automatic t_reset();
    check("R1 reset strobes", {accept, error, hash_start, fuse_burn_req, key_wr_en}, 0);
    check("R1 reset flags", {key_valid, busy, asleep}, 0);
    issue(8'h02, 8'd0, 16'd1);
    check("R1 fuses clear", rd_data, 0);
  endtask

  task automatic t_unknown();
    issue(8'hFF, 0, 0);
    check("R2 unknown opcode", {accept, error, hash_start}, 3'b010);
  endtask

  task automatic t_mac_nokey();
    issue(8'h08, 0, 0);
    check("R6 digest without key", {accept, error, hash_start}, 3'b010);
  endtask

  task automatic t_read();
    issue(8'h02, 8'd2, 16'd0);
    check("R3 key flag read", {accept, error}, 2'b10);
    check("R3 key flag value", rd_data, 0);
    issue(8'h02, 8'd1, 16'h0005);
    check("R3 id word, high addr bits ignored", rd_data, ROM_ID ^ 32'd1);
    issue(8'h02, 8'd0, 16'd3);
    check("R3 illegal fuse word", {accept, error}, 2'b01);
    issue(8'h02, 8'd3, 16'd0);
    check("R3 illegal source", {accept, error}, 2'b01);
  endtask

  task automatic t_burn();
    issue(8'h17, 8'd87, 0);
    check("R4 burn req", {accept, error, fuse_burn_req}, 3'b101);
    check("R4 burn idx", fuse_burn_idx, 87);
    issue(8'h02, 8'd0, 16'h0402);
    check("R4 fuse 87 in word 2", rd_data, 32'h0080_0000);
    issue(8'h17, 8'd5, 0);
    issue(8'h02, 8'd0, 16'd0);
    check("R4 fuse 5 in word 0", rd_data, 32'h20);
    issue(8'h17, 8'd88, 0);
    check("R4 index out of range", {accept, error, fuse_burn_req}, 3'b010);
  endtask

  task automatic t_burn_abort();
    supply_ok = 0;
    issue(8'h17, 8'd3, 0);
    supply_ok = 1;
    check("R5 low supply", {accept, error, fuse_burn_req}, 3'b010);
    wdog_cnt = 16'd15;
    issue(8'h17, 8'd3, 0);
    check("R5 watchdog window", {accept, error, fuse_burn_req}, 3'b010);
    issue(8'h02, 8'd0, 16'd0);
    check("R5 fuses unchanged", rd_data, 32'h20);
    wdog_cnt = 16'd16;
    issue(8'h17, 8'd3, 0);
    check("R5 window edge allowed", {accept, error, fuse_burn_req}, 3'b101);
    wdog_cnt = WD_OK;
    issue(8'h02, 8'd0, 16'd0);
    check("R4 fuse 3 added", rd_data, 32'h28);
  endtask

  task automatic t_key_paths();
    issue(8'h10, 0, 0);
    check("R8 key load without seed", {accept, error, key_wr_en}, 3'b010);
    issue(8'h20, 0, 0);
    finish_hash("R7 seed");
    issue(8'h02, 8'd2, 0);
    issue(8'h10, 0, 0);
    check("R10 marker cleared by other command", {accept, error, key_wr_en}, 3'b010);
    issue(8'h20, 0, 0);
    finish_hash("R7 seed");
    sleep_and_wake();
    issue(8'h02, 8'd1, 0);
    check("R13 read ignored while asleep test setup", {accept, error}, 2'b10);
    issue(8'h20, 0, 0);
    finish_hash("R7 seed");
    @(negedge clk); wdog_cnt = 0;
    @(negedge clk); wdog_cnt = WD_OK; wake = 1;
    @(negedge clk); wake = 0;
    issue(8'h10, 0, 0);
    check("R10 marker cleared by expiry", {accept, error, key_wr_en}, 3'b010);
    issue(8'h20, 0, 0);
    finish_hash("R7 seed");
    issue(8'h10, 0, 0);
    check("R9 key load ok", {accept, error, key_wr_en, key_valid}, 4'b1011);
    issue(8'h20, 0, 0);
    finish_hash("R7 seed");
    issue(8'h10, 0, 0);
    check("R9 second key load refused", {accept, error, key_wr_en, key_valid}, 4'b0101);
  endtask

  task automatic t_mac_ok();
    issue(8'h08, 0, 0);
    check("R6 digest no immediate verdict", {accept, error}, 2'b00);
    finish_hash("R6 digest");
    issue(8'h02, 8'd2, 0);
    check("R3 key flag now set", rd_data, 1);
  endtask

  task automatic t_sleep_ignore();
    @(negedge clk); wdog_cnt = 0;
    @(negedge clk); wdog_cnt = WD_OK;
    issue(8'h02, 8'd1, 0);
    check("R13 command ignored asleep", {accept, error, asleep}, 3'b001);
    wake = 1;
    @(negedge clk); wake = 0;
    check("R13 wake", asleep, 0);
  endtask

  task automatic t_pause();
    issue(8'h01, 0, 0);
    check("R11 pause accepted", {accept, error, busy}, 3'b101);
    issue(8'h02, 8'd1, 0);
    check("R11 command ignored while paused", {accept, error, busy}, 3'b001);
    @(negedge clk); wdog_cnt = 0;
    @(negedge clk); wdog_cnt = WD_OK;
    check("R11 pause ends in sleep", {busy, asleep}, 2'b01);
    wake = 1;
    @(negedge clk); wake = 0;
  endtask

  task automatic t_collide();
    @(negedge clk);
    cmd_valid = 1; cmd_op = 8'h02; cmd_p1 = 8'd1; cmd_p2 = 0; wdog_cnt = 0;
    @(negedge clk);
    cmd_valid = 0; wdog_cnt = WD_OK;
    check("R12 expiry wins over command", {accept, error, asleep}, 3'b001);
    wake = 1;
    @(negedge clk); wake = 0;
    issue(8'h02, 8'd1, 0);
    check("R12 block usable after wake", {accept, error}, 2'b10);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_unknown();
    t_mac_nokey();
    t_read();
    t_burn();
    t_burn_abort();
    t_key_paths();
    t_mac_ok();
    t_sleep_ignore();
    t_pause();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule